// File: doc/BRIEF.md
# Strided Vector Address Sequencer

This block turns one vector memory request into a stream of element addresses. A request carries a base word address, a signed stride, a total element count and a maximum register length. It is accepted through a start valid/ready handshake. The block then walks the vector one element per accepted output beat. The address moves from one element to the next by adding the stride to a running register, and two's complement arithmetic covers negative strides. Each beat also reports which interleaved memory bank the address falls in.

Vectors longer than the register length are cut into strips. A preparation phase reduces the count by repeated subtraction to find the remainder. The short remainder strip is issued first and the full-length strips follow it. When the count divides evenly, no short strip is issued. Each beat carries the element index, the strip number and a flag marking the last element of its strip. A `done` pulse marks the end of every request, including a request with zero elements.

Top module: `vas_seq`

## Requirements
- R1: After reset, `start_ready` is 1, and `out_valid` and `done` are 0. `start_ready` is 1 only while no request is in progress.
- R2: Element i has address `base + i*stride`, taken modulo 2^ADDR_W, where the stride is a signed two's complement number.
- R3: A request of N elements emits exactly N beats, with `out_elem` running 0, 1, ..., N-1 in order.
- R4: Let r = N mod L, where L is the maximum register length. If r is not 0, strip 0 holds r elements and every later strip holds L. If r is 0, every strip holds L. `out_strip` starts at 0 and rises by 1 with each new strip.
- R5: `out_last` is 1 exactly on the final element of each strip.
- R6: `out_bank` equals the low log2(BANKS) bits of `out_addr`, which is the address modulo BANKS. BANKS is a power of two between 64 and 1024.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr`, `out_bank`, `out_elem`, `out_strip` and `out_last` hold their values.
- R8: A request with N = 0 emits no beat. `done` is 1 for exactly the one cycle after the request is accepted.
- R9: `done` is 1 for exactly the one cycle after the final beat is accepted.
- R10: While a request is in progress, `start_valid` and the request inputs have no effect on the sequence being emitted.
- R11: When N is at most L, a single strip 0 of N elements is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Sequencer idle, request accepted when both are high |
| base_addr | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Signed word distance between consecutive elements |
| total_cnt | input | CNT_W | Number of elements N |
| max_len | input | LEN_W | Maximum register length L (at least 1) |
| out_valid | output | 1 | Element beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | ADDR_W | Element word address |
| out_bank | output | BANK_W | Interleaved bank of the address |
| out_elem | output | CNT_W | Element index within the request |
| out_strip | output | CNT_W | Strip number |
| out_last | output | 1 | Final element of the current strip |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The assertions assume that `max_len` is at least 1 whenever a request is accepted. With a zero length, the remainder phase would never end. The checker keeps its own copy of the stride, captured when a request is accepted. This lets it check the address step without depending on the input staying constant afterwards. The bench only starts requests with a length between 1 and 16. It changes the request inputs during a run only in the one scenario built to test that they are ignored. It drops `start_valid` before the final beat, so no second request starts by accident.

// File: rtl/vas_pkg.sv
package vas_pkg;

    typedef enum logic [1:0] {
        VAS_IDLE = 2'd0,
        VAS_PREP = 2'd1,
        VAS_RUN  = 2'd2
    } vas_state_e;

endpackage

// File: rtl/vas_addr_step.sv
module vas_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] nxt_addr
);
    // Two's complement add: a negative stride wraps downward without special case.
    always_comb begin
        nxt_addr = cur_addr + step;
    end
endmodule

// File: rtl/vas_bank_map.sv
module vas_bank_map #(
    parameter int ADDR_W = 32,
    parameter int BANKS  = 64,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank
);
    // BANKS is a power of two, so the modulo is a plain bit slice.
    always_comb begin
        bank = addr[BANK_W-1:0];
    end
endmodule

// File: rtl/vas_seq.sv
module vas_seq
    import vas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8,
    parameter int BANKS  = 64,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  total_cnt,
    input  logic [LEN_W-1:0]  max_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BANK_W-1:0] out_bank,
    output logic [CNT_W-1:0]  out_elem,
    output logic [CNT_W-1:0]  out_strip,
    output logic              out_last,
    output logic              done
);

    typedef struct packed {
        vas_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] step;
        logic [CNT_W-1:0]  total;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  elem;
        logic [CNT_W-1:0]  strip;
        logic [LEN_W-1:0]  left;
        logic              done;
    } vas_regs_t;

    vas_regs_t r_d, r_q;

    logic [ADDR_W-1:0] addr_nxt;
    logic [CNT_W-1:0]  len_ext;
    logic              fire;
    logic              strip_end;
    logic              vec_end;

    vas_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (r_q.addr),
        .step     (r_q.step),
        .nxt_addr (addr_nxt)
    );

    vas_bank_map #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_bank (
        .addr (r_q.addr),
        .bank (out_bank)
    );

    always_comb begin
        len_ext   = CNT_W'(r_q.len);
        fire      = (r_q.st == VAS_RUN) && out_ready;
        strip_end = (r_q.left == LEN_W'(1));
        vec_end   = (r_q.elem + CNT_W'(1)) == r_q.total;

        r_d      = r_q;
        r_d.done = 1'b0;

        case (r_q.st)
            VAS_IDLE: begin
                if (start_valid) begin
                    r_d.addr  = base_addr;
                    r_d.step  = stride;
                    r_d.total = total_cnt;
                    r_d.len   = max_len;
                    r_d.rem   = total_cnt;
                    r_d.elem  = '0;
                    r_d.strip = '0;
                    if (total_cnt == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = VAS_PREP;
                    end
                end
            end
            VAS_PREP: begin
                // Remainder by repeated subtraction: one compare and subtract per cycle.
                if (r_q.rem >= len_ext) begin
                    r_d.rem = r_q.rem - len_ext;
                end else begin
                    r_d.st   = VAS_RUN;
                    r_d.left = (r_q.rem == '0) ? r_q.len : r_q.rem[LEN_W-1:0];
                end
            end
            VAS_RUN: begin
                if (fire) begin
                    r_d.addr = addr_nxt;
                    r_d.elem = r_q.elem + CNT_W'(1);
                    if (strip_end) begin
                        if (vec_end) begin
                            r_d.st   = VAS_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.strip = r_q.strip + CNT_W'(1);
                            r_d.left  = r_q.len;
                        end
                    end else begin
                        r_d.left = r_q.left - LEN_W'(1);
                    end
                end
            end
            default: begin
                r_d.st = VAS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= VAS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        start_ready = (r_q.st == VAS_IDLE);
        out_valid   = (r_q.st == VAS_RUN);
        out_addr    = r_q.addr;
        out_elem    = r_q.elem;
        out_strip   = r_q.strip;
        out_last    = (r_q.st == VAS_RUN) && (r_q.left == LEN_W'(1));
        done        = r_q.done;
    end

endmodule

// File: rtl/vas_seq_chk.sv
module vas_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BANK_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic [ADDR_W-1:0] stride,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [BANK_W-1:0] out_bank,
    input logic [CNT_W-1:0]  out_elem,
    input logic [CNT_W-1:0]  out_strip,
    input logic              out_last,
    input logic              done
);
    logic [ADDR_W-1:0] cap_stride;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_stride <= '0;
        end else if (start_valid && start_ready) begin
            cap_stride <= stride;
        end
    end

    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_bank)
            && $stable(out_elem) && $stable(out_strip) && $stable(out_last)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_addr == $past(out_addr) + cap_stride));

    // R3
    elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_elem == $past(out_elem) + CNT_W'(1)));

    // R4
    strip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (done ||
            (out_valid && out_strip == $past(out_strip) + CNT_W'(1))));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

endmodule

bind vas_seq vas_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BANK_W (BANK_W)
) i_vas_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .stride      (stride),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_bank    (out_bank),
    .out_elem    (out_elem),
    .out_strip   (out_strip),
    .out_last    (out_last),
    .done        (done)
);

// File: tb/test_vas_seq.sv
module test_vas_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int LEN_W  = 8;
    localparam int BANKS  = 64;
    localparam int BANK_W = $clog2(BANKS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic              start_ready;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] stride = '0;
    logic [CNT_W-1:0]  total_cnt = '0;
    logic [LEN_W-1:0]  max_len = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] out_addr;
    logic [BANK_W-1:0] out_bank;
    logic [CNT_W-1:0]  out_elem;
    logic [CNT_W-1:0]  out_strip;
    logic              out_last;
    logic              done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vas_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .BANKS(BANKS)) i_vas_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .base_addr(base_addr), .stride(stride), .total_cnt(total_cnt), .max_len(max_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_bank(out_bank),
        .out_elem(out_elem), .out_strip(out_strip), .out_last(out_last), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Drives one request and checks every beat against base + i*stride and the strip layout.
    task automatic run_vec(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
                           input int tot, input int ml, input bit stall, input bit poke);
        int first_len;
        int got;
        logic [7:0] lfsr;
        bit was_stall;
        logic rdy;
        logic [ADDR_W-1:0] s_addr;
        logic [CNT_W-1:0] s_elem;
        logic [CNT_W-1:0] s_strip;
        logic s_last;
        logic [ADDR_W-1:0] e_addr;
        int e_strip;
        int pos;
        int len;
        first_len = tot % ml;
        if (first_len == 0) first_len = ml;
        @(negedge clk);
        chk(start_ready == 1'b1, "R1", "start_ready before request", start_ready, 1);
        base_addr = b; stride = s; total_cnt = CNT_W'(tot); max_len = LEN_W'(ml);
        start_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            // R10: keep offering a different request while busy
            base_addr = 32'h5555_0000; stride = 32'd99; total_cnt = 16'd3; max_len = 8'd1;
        end else begin
            start_valid = 1'b0;
        end
        got = 0; lfsr = 8'hA5; was_stall = 1'b0;
        s_addr = '0; s_elem = '0; s_strip = '0; s_last = 1'b0;
        while (got < tot) begin
            if (poke && got >= 3) start_valid = 1'b0;
            rdy = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (out_valid) begin
                if (was_stall) begin
                    chk(out_addr == s_addr, "R7", "addr held in stall", out_addr, s_addr);
                    chk(out_elem == s_elem && out_strip == s_strip && out_last == s_last,
                        "R7", "index held in stall", out_elem, s_elem);
                end
                e_addr = b + ADDR_W'(got) * s;
                if (got < first_len) begin
                    e_strip = 0; pos = got; len = first_len;
                end else begin
                    e_strip = 1 + (got - first_len) / ml;
                    pos = (got - first_len) % ml;
                    len = ml;
                end
                chk(out_addr == e_addr, "R2", "address", out_addr, e_addr);
                chk(out_bank == e_addr[BANK_W-1:0], "R6", "bank", out_bank, e_addr[BANK_W-1:0]);
                chk(int'(out_elem) == got, "R3", "element index", out_elem, got);
                chk(int'(out_strip) == e_strip, "R4", "strip number", out_strip, e_strip);
                chk(out_last == (pos == len - 1), "R5", "last in strip", out_last, (pos == len - 1));
                s_addr = out_addr; s_elem = out_elem; s_strip = out_strip; s_last = out_last;
                was_stall = !rdy;
                if (rdy) got++;
            end else if (was_stall) begin
                chk(1'b0, "R7", "valid dropped in stall", 0, 1);
                was_stall = 1'b0;
            end
            out_ready = rdy;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            @(negedge clk);
        end
        out_ready = 1'b1;
        chk(done == 1'b1, "R9", "done after final beat", done, 1);
        chk(out_valid == 1'b0, "R3", "no beat beyond count", out_valid, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle only", done, 0);
        chk(start_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after request", start_ready, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(start_ready == 1'b1, "R1", "reset start_ready", start_ready, 1);
        chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
    endtask

    task automatic test_zero();
        @(negedge clk);
        base_addr = 32'h100; stride = 32'd1; total_cnt = '0; max_len = 8'd4;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        chk(done == 1'b1, "R8", "zero count done", done, 1);
        chk(out_valid == 1'b0, "R8", "zero count no beat", out_valid, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "zero count pulse width", done, 0);
        chk(out_valid == 1'b0, "R8", "zero count still no beat", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_vec(32'h0000_1000, 32'd1, 10, 4, 1'b0, 1'b0);          // R4 remainder strip 2 then 4,4
        run_vec(32'h0000_0200, 32'hFFFF_FFFD, 8, 8, 1'b0, 1'b0);   // R2 negative stride, R4 no remainder
        run_vec(32'hFFFF_FFF0, 32'd7, 5, 16, 1'b0, 1'b0);          // R11 short vector, R2 wrap
        run_vec(32'h0000_0040, 32'd2, 13, 5, 1'b1, 1'b0);          // R7 stalls
        test_zero();                                               // R8
        run_vec(32'h0000_0800, 32'd5, 6, 3, 1'b0, 1'b1);           // R10 start ignored while busy
        run_vec(32'h0000_0003, 32'd64, 9, 2, 1'b1, 1'b0);          // R6 same bank every element
        run_vec(32'h0000_0000, 32'd1, 1, 1, 1'b0, 1'b0);           // R11 single element
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule